// File: doc/BRIEF.md
# Swept Sensor Frame Readout Controller

This controller sits on the host side of a linear swept-finger image sensor. It drives the sensor's reset, pixel clock, output-enable and heater-enable pins and captures the 8-bit data bus. Each captured byte carries two 4-bit pixels, with the odd-row pixel in bits 7:4 and the even-row pixel in bits 3:0. The block delivers every captured byte on a valid/ready stream. Each byte is tagged with its column number and its row-pair number inside that column.

The controller wakes when `nap_req` falls. It then applies a reset pulse and four pipeline-fill clocks, and reads one full frame that it throws away. From then on it reads frames of `NCOLS` columns times `PAIRS` bytes, back to back or on a fixed start-to-start period, until `nap_req` rises. It then finishes the current frame, waits out the output-enable quiet window and puts the sensor to sleep. The clock half-period, the frame period and the quiet window are runtime inputs counted in system clocks.

A byte that arrives while the small output buffer is full is dropped, and a sticky error flag is raised. The sensor clock never stalls.

Top module: `sweep_frame_reader`

## Requirements
- R1: After `rst_n` is released the sensor is in the sleep state: `sen_rst`=1, `sen_clk`=0, `sen_oe_n`=1, `sen_tpe`=0. At the same time `m_valid`, `frame_done` and `skid_ovf` are 0.
- R2: When `nap_req` falls, `sen_oe_n` goes low. `sen_rst` falls exactly `cfg_half` cycles later, and the first `sen_clk` rise comes exactly `cfg_half` cycles after that.
- R3: Every high phase of `sen_clk` lasts exactly `cfg_half` system clocks, and every low phase lasts at least `cfg_half`.
- R4: After a wake, the first 4 clock pulses and the next `NCOLS*PAIRS` pulses (one whole frame) produce no stream output. The first byte delivered belongs to the second frame.
- R5: The bus is sampled on the last cycle of each pulse's low phase. A byte at position p of a frame is delivered unchanged with `m_col` = p/PAIRS and `m_pair` = p mod PAIRS, so `m_col*PAIRS+m_pair` = p.
- R6: Frame k+1 starts its first rise max(`cfg_period`, `NCOLS*PAIRS*2*cfg_half`) cycles after frame k started. A late frame is delayed and is never skipped.
- R7: `frame_done` is a single-cycle pulse in the cycle after the last byte of each delivered frame is sampled. It does not fire for the thrown-away frame.
- R8: While `m_valid`=1 and `m_ready`=0, `m_valid` stays 1 and `m_data`, `m_col` and `m_pair` hold their values.
- R9: A byte that arrives with the buffer full and no pop is dropped and `skid_ovf` is set until reset. Sensor clock pulses continue during the stall.
- R10: Sleep is entered only at a frame boundary. On entry, `sen_rst`=1, `sen_oe_n`=1, `sen_tpe`=0 and `sen_clk` stays low.
- R11: `sen_oe_n` never changes within `cfg_quiet` system clocks after a `sen_clk` fall.
- R12: `sen_rst` is low whenever `sen_clk` is high.
- R13: `sen_tpe` follows `tpe_req` while awake and is 0 during sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | HALF_W | Sensor clock phase length in system clocks (>=1) |
| cfg_period | input | PER_W | Frame start-to-start period in system clocks |
| cfg_quiet | input | QUIET_W | Cycles after a clock fall during which output-enable is frozen |
| nap_req | input | 1 | 1 = put the sensor to sleep at the next frame boundary |
| tpe_req | input | 1 | Requested heater enable while awake |
| sen_rst | output | 1 | Sensor reset pin |
| sen_clk | output | 1 | Sensor pixel clock |
| sen_oe_n | output | 1 | Sensor output enable, active low |
| sen_tpe | output | 1 | Sensor heater enable |
| sen_data | input | 8 | Sensor data bus: odd pixel [7:4], even pixel [3:0] |
| m_valid | output | 1 | Stream byte valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | 8 | Captured byte |
| m_col | output | COL_W | Column index of the byte |
| m_pair | output | PAIR_W | Row-pair index inside the column |
| frame_done | output | 1 | One-cycle pulse after a delivered frame's last byte |
| skid_ovf | output | 1 | Sticky buffer-overflow flag |

## Verification
The properties assume that `cfg_half` is at least 1 and that all configuration inputs change only while the sensor sleeps. Otherwise the phase-length and quiet-window checks compare against moving targets. The stimulus draws a new half-period, period, quiet window and heater setting only between a sleep entry and the next wake. It keeps the half-period long enough for the pin timing and the quiet window both shorter and longer than a phase. Stream back-pressure is randomised on every cycle but stays light. The one deliberate overflow, with the consumer held off, is run last.

// File: rtl/sweep_frame_reader.sv
module sweep_frame_reader #(
  parameter int NCOLS       = 281,
  parameter int PAIRS       = 4,
  parameter int FILL_PULSES = 4,
  parameter int SKID_DEPTH  = 2,
  parameter int HALF_W      = 8,
  parameter int PER_W       = 20,
  parameter int QUIET_W     = 8,
  localparam int COL_W  = $clog2(NCOLS),
  localparam int PAIR_W = $clog2(PAIRS),
  localparam int FC_W   = $clog2(FILL_PULSES),
  localparam int SK_W   = $clog2(SKID_DEPTH),
  localparam int EW     = 8 + COL_W + PAIR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HALF_W-1:0]  cfg_half,
  input  logic [PER_W-1:0]   cfg_period,
  input  logic [QUIET_W-1:0] cfg_quiet,
  input  logic               nap_req,
  input  logic               tpe_req,
  output logic               sen_rst,
  output logic               sen_clk,
  output logic               sen_oe_n,
  output logic               sen_tpe,
  input  logic [7:0]         sen_data,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [7:0]         m_data,
  output logic [COL_W-1:0]   m_col,
  output logic [PAIR_W-1:0]  m_pair,
  output logic               frame_done,
  output logic               skid_ovf
);

  typedef enum logic [2:0] {S_NAP, S_RST, S_FILL, S_FRAME, S_WAIT, S_QUIET} st_t;

  st_t                st;
  logic [HALF_W-1:0]  ph;
  logic [FC_W-1:0]    fill_n;
  logic [COL_W-1:0]   col;
  logic [PAIR_W-1:0]  pair;
  logic               discard;
  logic [PER_W-1:0]   per_cnt;
  logic [QUIET_W-1:0] quiet;

  logic [EW-1:0]      sk [SKID_DEPTH];
  logic [SK_W-1:0]    wr, rd;
  logic [SK_W:0]      cnt;

  wire ph_end    = ph == cfg_half - 1'b1;
  wire pulsing   = (st == S_FILL) || (st == S_FRAME);
  wire low_end   = pulsing && !sen_clk && ph_end;
  wire last_byte = (col == COL_W'(NCOLS-1)) && (pair == PAIR_W'(PAIRS-1));
  wire per_ok    = per_cnt >= cfg_period;
  wire grab      = low_end && (st == S_FRAME) && !discard;
  wire pop       = m_valid && m_ready;
  wire full      = cnt == (SK_W+1)'(SKID_DEPTH);
  wire push      = grab && (!full || pop);

  assign sen_tpe = tpe_req && (st != S_NAP);
  assign m_valid = cnt != '0;
  assign {m_data, m_col, m_pair} = sk[rd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_NAP;
      sen_rst    <= 1'b1;
      sen_clk    <= 1'b0;
      sen_oe_n   <= 1'b1;
      ph         <= '0;
      fill_n     <= '0;
      col        <= '0;
      pair       <= '0;
      discard    <= 1'b1;
      per_cnt    <= '0;
      quiet      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= grab && last_byte;
      if (per_cnt != '1) per_cnt <= per_cnt + 1'b1;
      if (quiet != '0) quiet <= quiet - 1'b1;
      case (st)
        S_NAP: if (!nap_req) begin
          st       <= S_RST;
          sen_oe_n <= 1'b0;
          ph       <= '0;
        end
        S_RST: if (ph_end) begin
          ph <= '0;
          if (sen_rst) sen_rst <= 1'b0;
          else begin
            sen_clk <= 1'b1;
            fill_n  <= '0;
            st      <= S_FILL;
          end
        end else ph <= ph + 1'b1;
        S_FILL, S_FRAME: begin
          if (sen_clk) begin
            if (ph_end) begin
              sen_clk <= 1'b0;
              ph      <= '0;
              quiet   <= cfg_quiet;
            end else ph <= ph + 1'b1;
          end else if (!ph_end) begin
            ph <= ph + 1'b1;
          end else begin
            ph <= '0;
            if (st == S_FILL) begin
              sen_clk <= 1'b1;
              if (fill_n == FC_W'(FILL_PULSES-1)) begin
                st      <= S_FRAME;
                discard <= 1'b1;
                col     <= '0;
                pair    <= '0;
                per_cnt <= PER_W'(1);
              end else fill_n <= fill_n + 1'b1;
            end else if (!last_byte) begin
              sen_clk <= 1'b1;
              if (pair == PAIR_W'(PAIRS-1)) begin
                pair <= '0;
                col  <= col + 1'b1;
              end else pair <= pair + 1'b1;
            end else if (nap_req) begin
              st <= S_QUIET;
            end else if (per_ok) begin
              sen_clk <= 1'b1;
              discard <= 1'b0;
              col     <= '0;
              pair    <= '0;
              per_cnt <= PER_W'(1);
            end else st <= S_WAIT;
          end
        end
        S_WAIT: if (nap_req) st <= S_QUIET;
        else if (per_ok) begin
          st      <= S_FRAME;
          sen_clk <= 1'b1;
          ph      <= '0;
          discard <= 1'b0;
          col     <= '0;
          pair    <= '0;
          per_cnt <= PER_W'(1);
        end
        S_QUIET: if (quiet == '0) begin
          st       <= S_NAP;
          sen_oe_n <= 1'b1;
          sen_rst  <= 1'b1;
        end
        default: st <= S_NAP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr       <= '0;
      rd       <= '0;
      cnt      <= '0;
      skid_ovf <= 1'b0;
    end else begin
      if (push) wr <= wr + 1'b1;
      if (pop) rd <= rd + 1'b1;
      cnt      <= cnt + (SK_W+1)'(push) - (SK_W+1)'(pop);
      skid_ovf <= skid_ovf | (grab && full && !pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) sk[wr] <= {sen_data, col, pair};
  end

endmodule

// File: rtl/sweep_frame_reader_chk.sv
module sweep_frame_reader_chk #(
  parameter int HALF_W  = 8,
  parameter int QUIET_W = 8,
  parameter int COL_W   = 9,
  parameter int PAIR_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [HALF_W-1:0]  cfg_half,
  input logic [QUIET_W-1:0] cfg_quiet,
  input logic               sen_rst,
  input logic               sen_clk,
  input logic               sen_oe_n,
  input logic               sen_tpe,
  input logic               m_valid,
  input logic               m_ready,
  input logic [7:0]         m_data,
  input logic [COL_W-1:0]   m_col,
  input logic [PAIR_W-1:0]  m_pair,
  input logic               frame_done,
  input logic               skid_ovf
);

  logic [HALF_W:0]  hi_run, lo_run;
  logic [QUIET_W:0] since_fall;
  logic             clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run     <= '0;
      lo_run     <= '0;
      since_fall <= '1;
      clk_q      <= 1'b0;
    end else begin
      clk_q      <= sen_clk;
      hi_run     <= sen_clk ? ((hi_run != '1) ? hi_run + 1'b1 : hi_run) : '0;
      lo_run     <= !sen_clk ? ((lo_run != '1) ? lo_run + 1'b1 : lo_run) : '0;
      since_fall <= (clk_q && !sen_clk) ? (QUIET_W+1)'(1)
                  : ((since_fall != '1) ? since_fall + 1'b1 : since_fall);
    end
  end

  a_r3_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sen_clk) |-> hi_run == {1'b0, cfg_half});

  a_r3_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sen_clk) |-> lo_run >= {1'b0, cfg_half});

  a_r11_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sen_oe_n) |-> (!$fell(sen_clk) && since_fall >= {1'b0, cfg_quiet}));

  a_r12_rst_low_when_clk: assert property (@(posedge clk) disable iff (!rst_n)
    sen_clk |-> !sen_rst);

  a_r10_nap_pins: assert property (@(posedge clk) disable iff (!rst_n)
    sen_oe_n |-> (sen_rst && !sen_clk && !sen_tpe));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_col) && $stable(m_pair)));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    skid_ovf |=> skid_ovf);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

endmodule

bind sweep_frame_reader sweep_frame_reader_chk #(
  .HALF_W(HALF_W), .QUIET_W(QUIET_W), .COL_W(COL_W), .PAIR_W(PAIR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_quiet(cfg_quiet),
  .sen_rst(sen_rst), .sen_clk(sen_clk), .sen_oe_n(sen_oe_n), .sen_tpe(sen_tpe),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_col(m_col),
  .m_pair(m_pair), .frame_done(frame_done), .skid_ovf(skid_ovf)
);

// File: tb/test_sweep_frame_reader.sv
module swept_sensor_model #(parameter int FB = 24) (
  input  logic       s_rst,
  input  logic       s_clk,
  input  logic       s_oe_n,
  output wire  [7:0] s_data
);
  int unsigned n;
  logic [7:0]  q;

  function automatic logic [7:0] pat(int unsigned g);
    int unsigned f = g / FB;
    int unsigned p = g % FB;
    return 8'(f * 29 + p * 7 + 60);
  endfunction

  always @(posedge s_clk or posedge s_rst)
    if (s_rst) begin
      n <= 0;
      q <= 8'h00;
    end else begin
      n <= n + 1;
      if (n >= 4) q <= pat(n - 4);
    end

  assign s_data = s_oe_n ? 8'hzz : q;
endmodule

module test_sweep_frame_reader;
  localparam int NCOLS = 6;
  localparam int PAIRS = 4;
  localparam int FB    = NCOLS * PAIRS;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0]  cfg_half = 8'd32;
  logic [19:0] cfg_period = '0;
  logic [7:0]  cfg_quiet = '0;
  logic nap_req = 1, tpe_req = 0, m_ready = 1;
  logic sen_rst, sen_clk, sen_oe_n, sen_tpe, m_valid, frame_done, skid_ovf;
  wire  [7:0] sen_data;
  logic [7:0] m_data;
  logic [2:0] m_col;
  logic [1:0] m_pair;

  always #4 clk = ~clk;

  sweep_frame_reader #(.NCOLS(NCOLS), .PAIRS(PAIRS)) i_sweep_frame_reader (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_period(cfg_period),
    .cfg_quiet(cfg_quiet), .nap_req(nap_req), .tpe_req(tpe_req),
    .sen_rst(sen_rst), .sen_clk(sen_clk), .sen_oe_n(sen_oe_n), .sen_tpe(sen_tpe),
    .sen_data(sen_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_col(m_col), .m_pair(m_pair), .frame_done(frame_done), .skid_ovf(skid_ovf));

  swept_sensor_model #(.FB(FB)) i_model (
    .s_rst(sen_rst), .s_clk(sen_clk), .s_oe_n(sen_oe_n), .s_data(sen_data));

  int checks = 0, fails = 0, cyc = 0;
  int H = 32, P = 0, Q = 0;
  int rcnt = 0, fcnt = 0, ef = 1, ep = 0, nbytes = 0, ndone = 0;
  int rise_cyc = 0, last_fall = 0, oe_fall_cyc = 0, rst_fall_cyc = 0, fstart = 0;
  bit have_fall = 0, chk_bytes = 1, stall = 0, hold_pend = 0, finished = 0;
  logic pclk = 0, prst = 1, poe = 1;
  logic [7:0] hold_d;

  function automatic logic [7:0] exp_byte(int f, int p);
    return 8'(f * 29 + p * 7 + 60);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    void'($urandom(32'd20240611));
    forever begin
      @(posedge clk);
      #1;
      m_ready = stall ? 1'b0 : (($urandom % 4) != 0);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (sen_clk && !pclk) begin
        rcnt++;
        chk(!sen_rst, "R12 reset low at rise", int'(sen_rst), 0);
        if (rcnt == 1) chk(cyc - rst_fall_cyc == H, "R2 reset fall to first rise", cyc - rst_fall_cyc, H);
        if (rcnt >= 5 && (rcnt - 5) % FB == 0) begin
          if (rcnt >= 5 + FB)
            chk(cyc - fstart == imax(P, FB * 2 * H), "R6 frame start spacing",
                cyc - fstart, imax(P, FB * 2 * H));
          fstart = cyc;
        end
        rise_cyc = cyc;
      end
      if (!sen_clk && pclk) begin
        fcnt++;
        chk(cyc - rise_cyc == H, "R3 high phase length", cyc - rise_cyc, H);
        last_fall = cyc;
        have_fall = 1;
      end
      if (!sen_rst && prst) begin
        rst_fall_cyc = cyc;
        chk(cyc - oe_fall_cyc == H, "R2 oe fall to reset fall", cyc - oe_fall_cyc, H);
      end
      if (sen_oe_n != poe) begin
        if (have_fall) chk(cyc - last_fall >= Q, "R11 oe quiet window", cyc - last_fall, Q);
        if (!sen_oe_n) begin
          oe_fall_cyc = cyc;
          rcnt = 0; fcnt = 0; ef = 1; ep = 0;
        end else begin
          chk(fcnt >= 4 + FB && (fcnt - 4) % FB == 0, "R10 nap at frame boundary", fcnt, 4 + FB);
          chk(sen_rst && !sen_clk && !sen_tpe, "R10 nap pins", {sen_rst, sen_clk, sen_tpe}, 4);
        end
      end
      if (frame_done) begin
        ndone++;
        chk(fcnt >= 4 + 2 * FB && (fcnt - 4) % FB == 0, "R7 frame_done position", fcnt, 4 + 2 * FB);
      end
      if (hold_pend) begin
        chk(m_valid && m_data == hold_d, "R8 hold under back-pressure", int'(m_data), int'(hold_d));
        hold_pend = 0;
      end
      if (m_valid && !m_ready) begin
        hold_pend = 1;
        hold_d = m_data;
      end
      if (m_valid && m_ready) begin
        nbytes++;
        if (chk_bytes) begin
          if (ef == 1 && ep == 0)
            chk(m_data == exp_byte(1, 0), "R4 first byte is from second frame", int'(m_data), int'(exp_byte(1, 0)));
          chk(m_data == exp_byte(ef, ep), "R5 byte value", int'(m_data), int'(exp_byte(ef, ep)));
          chk(int'(m_col) * PAIRS + int'(m_pair) == ep, "R5 column/pair tag",
              int'(m_col) * PAIRS + int'(m_pair), ep);
        end
        ep++;
        if (ep == FB) begin ep = 0; ef++; end
      end
    end
    pclk = sen_clk; prst = sen_rst; poe = sen_oe_n;
  end

  task automatic run_round(input int h, input int per, input int q, input bit tpe, input int frames);
    int b0, d0, r0;
    @(posedge clk); #1;
    H = h; P = per; Q = q;
    cfg_half = 8'(h); cfg_period = 20'(per); cfg_quiet = 8'(q); tpe_req = tpe;
    b0 = nbytes; d0 = ndone;
    nap_req = 0;
    while (nbytes - b0 < frames * FB) @(posedge clk);
    #1;
    chk(sen_tpe == tpe, "R13 heater follows request", int'(sen_tpe), int'(tpe));
    nap_req = 1;
    while (!sen_oe_n) @(posedge clk);
    repeat (3) @(posedge clk);
    chk(ndone - d0 >= frames, "R7 frame_done count", ndone - d0, frames);
    chk(!sen_tpe, "R13 heater off in nap", int'(sen_tpe), 0);
    r0 = rcnt;
    repeat (200) @(posedge clk);
    chk(rcnt == r0 && !sen_clk, "R10 clock static in nap", rcnt - r0, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(sen_rst && !sen_clk && sen_oe_n && !sen_tpe, "R1 sensor pins after reset",
        {sen_rst, sen_clk, sen_oe_n, sen_tpe}, 10);
    chk(!m_valid && !frame_done && !skid_ovf, "R1 stream idle after reset",
        {m_valid, frame_done, skid_ovf}, 0);
    repeat (20) @(posedge clk);

    run_round(32, 100, 10, 1'b1, 3);
    run_round(33, 0, 120, 1'b0, 2);
    for (int i = 0; i < 3; i++)
      run_round(32 + int'($urandom % 9), 1000 + int'($urandom % 1500),
                int'($urandom % 121), 1'(($urandom % 2)), 2 + int'($urandom % 2));

    begin
      int b0, r0, g;
      @(posedge clk); #1;
      H = 32; P = 0; Q = 5;
      cfg_half = 8'd32; cfg_period = '0; cfg_quiet = 8'd5;
      b0 = nbytes;
      nap_req = 0;
      while (nbytes - b0 < 2) @(posedge clk);
      #1;
      chk_bytes = 0;
      stall = 1;
      r0 = rcnt;
      g = 0;
      while (!skid_ovf && g < 2000) begin @(posedge clk); g++; end
      repeat (400) @(posedge clk);
      chk(skid_ovf, "R9 overflow flag set", int'(skid_ovf), 1);
      chk(rcnt - r0 >= 5, "R9 clock keeps running while stalled", rcnt - r0, 5);
      stall = 0;
      nap_req = 1;
      while (!sen_oe_n) @(posedge clk);
      repeat (10) @(posedge clk);
      chk(skid_ovf, "R9 overflow flag sticky", int'(skid_ovf), 1);
    end
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule